// File: doc/BRIEF.md
# Four-Channel Bus-Master DMA Controller

This block moves bytes between an I/O device and memory without CPU involvement. A device raises its request line. The controller picks the most urgent eligible channel and asks the CPU for the bus. Once the CPU grants the bus, the controller drives one byte transfer per clock. Each transfer uses an acknowledge to the device, a 16-bit memory address, and a pair of read/write strobes whose direction depends on the channel's mode.

Software programs each channel through an 8-bit register port. This covers the start address, the byte count, the direction and block/demand mode, and the mask bits. When a channel's count runs out, the controller pulses end-of-process and marks the channel finished. That channel stays inert until software writes a new count. The memory address is a plain 16-bit counter, so it rolls over from 0xFFFF to 0x0000 and never reaches into a higher page.

Top module: `dmac_core`

## Requirements
- R1: After reset, `hrq` is 0, every `dack_n` bit is 1, all strobes and `eop_n` are 1, and all channels are masked, so a programmed channel with its request high gets no service.
- R2: A channel is serviced only when its request is high, it is unmasked, and it is armed. Writing a high count byte arms a channel if the 16-bit count is nonzero. A channel that has never been given a nonzero count is never serviced.
- R3: Priority is fixed: channel 0 is highest and channel 3 lowest. Arbitration happens only while `hrq` and `hlda` are both low.
- R4: After choosing a channel, the controller raises `hrq`. The first byte cycle begins on the clock edge at which `hlda` is sampled high, and acknowledges and strobes are active only while both `hrq` and `hlda` are high.
- R5: Each byte cycle lasts one clock. In it exactly one `dack_n` bit is low, `mem_addr` holds the channel's current address, and the strobes are set by mode bit 2. When the bit is 1 (device to memory), `ior_n` and `memw_n` are low. When it is 0, `memr_n` and `iow_n` are low. After each byte, the address increments and the count decrements.
- R6: The address wraps from 0xFFFF to 0x0000.
- R7: `eop_n` is low during exactly the last byte of a count. On the next clock `hrq` falls, the channel is disarmed, and its terminal-count status bit is set. The channel is not serviced again until its count is rewritten.
- R8: In block mode (mode bit 3 = 0), once the first byte has started the whole count is transferred even if the request drops.
- R9: In demand mode (mode bit 3 = 1), the controller samples the request at the end of each byte. If it is low, the controller releases the bus without asserting `eop_n`. When the request returns, transfer resumes at the same address and remaining count.
- R10: The controller holds a single low/high byte pointer, which is shared by every channel address and count register. Register offset 2n reaches channel n's address and offset 2n+1 reaches its count. The low byte comes first, and the pointer toggles on every read or write of offsets 0–7. A write to offset 11 resets the pointer to low. A read returns the current value.
- R11: The mask controls work as follows.
  - Offset 9 sets one channel's mask bit: bits [1:0] choose the channel and bit 2 gives the new mask value.
  - Offset 10 writes one channel's mode: bits [1:0] choose the channel.
  - Offset 13 clears every mask bit.
  - Offset 14 loads all four mask bits from data bits [3:0].
  - Offset 12 performs a master clear: it idles the controller, disarms every channel and masks them all.
- R12: A read at offset 8 returns the terminal-count flags in bits [3:0] and the request lines in bits [7:4], and clears the terminal-count flags. `cpu_rdata` is valid on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drq | input | 4 | Per-channel transfer request |
| dack_n | output | 4 | Per-channel acknowledge, active low |
| hrq | output | 1 | Bus request to the CPU |
| hlda | input | 1 | Bus grant from the CPU |
| mem_addr | output | 16 | Memory address of the current byte |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| eop_n | output | 1 | End of process, active low, during the last byte |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_addr | input | 4 | Register offset |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data, registered |

## Verification
The assertions assume that `hlda` rises only while `hrq` is high and falls only after `hrq` has dropped. They also assume that software does not issue a master clear or rewrite a channel while that channel owns the bus. The bench's bus-grant responder raises `hlda` only after it observes `hrq`, and drops it once `hrq` falls. Every register access takes place while the controller is idle, so the byte-cycle checks on one-hot acknowledges, strobe direction and address stepping rest on those conditions.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_XFER} seq_state_t;

  localparam int RAW = 4;
  localparam logic [RAW-1:0] REG_STATUS  = 4'd8;
  localparam logic [RAW-1:0] REG_SMASK   = 4'd9;
  localparam logic [RAW-1:0] REG_MODE    = 4'd10;
  localparam logic [RAW-1:0] REG_CLRPTR  = 4'd11;
  localparam logic [RAW-1:0] REG_MCLR    = 4'd12;
  localparam logic [RAW-1:0] REG_CLRMASK = 4'd13;
  localparam logic [RAW-1:0] REG_ALLMASK = 4'd14;
endpackage

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int DW  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic                     re,
  input  logic [RAW-1:0]           addr,
  input  logic [DW-1:0]            wdata,
  input  logic [NCH-1:0]           drq,
  input  logic                     step,
  input  logic [((NCH>1)?$clog2(NCH):1)-1:0] step_ch,
  output logic [DW-1:0]            rdata,
  output logic [NCH-1:0][AW-1:0]   cur_addr,
  output logic [NCH-1:0][CW-1:0]   cur_cnt,
  output logic [NCH-1:0]           armed,
  output logic [NCH-1:0]           mask,
  output logic [NCH-1:0]           dir,
  output logic [NCH-1:0]           demand,
  output logic                     mclr
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic           ptr;
  logic [NCH-1:0] tc;
  logic           ch_hit;

  assign mclr   = we && (addr == REG_MCLR);
  assign ch_hit = (we || re) && !addr[RAW-1];

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      armed    <= '0;
      mask     <= '1;
      dir      <= '0;
      demand   <= '0;
      tc       <= '0;
      ptr      <= 1'b0;
      rdata    <= '0;
    end else begin
      if (re && addr == REG_STATUS) begin
        rdata <= DW'({drq, tc});
        tc    <= '0;
      end
      if (ch_hit) ptr <= !ptr;
      if (we && addr == REG_CLRPTR) ptr <= 1'b0;

      for (int i = 0; i < NCH; i++) begin
        if (ch_hit && addr[CHW:1] == CHW'(i)) begin
          if (re) begin
            if (!addr[0]) rdata <= ptr ? DW'(cur_addr[i][AW-1:DW]) : cur_addr[i][DW-1:0];
            else          rdata <= ptr ? DW'(cur_cnt[i][CW-1:DW])  : cur_cnt[i][DW-1:0];
          end
          if (we) begin
            if (!addr[0]) begin
              if (!ptr) cur_addr[i][DW-1:0]  <= wdata;
              else      cur_addr[i][AW-1:DW] <= (AW-DW)'(wdata);
            end else begin
              if (!ptr) cur_cnt[i][DW-1:0] <= wdata;
              else begin
                cur_cnt[i][CW-1:DW] <= (CW-DW)'(wdata);
                armed[i] <= (wdata != '0) || (cur_cnt[i][DW-1:0] != '0);
              end
            end
          end
        end
        if (we && addr == REG_MODE && wdata[CHW-1:0] == CHW'(i)) begin
          dir[i]    <= wdata[2];
          demand[i] <= wdata[3];
        end
        if (we && addr == REG_SMASK && wdata[CHW-1:0] == CHW'(i))
          mask[i] <= wdata[2];
        if (step && step_ch == CHW'(i)) begin
          cur_addr[i] <= cur_addr[i] + 1'b1;
          cur_cnt[i]  <= cur_cnt[i] - 1'b1;
          if (cur_cnt[i] == CW'(1)) begin
            armed[i] <= 1'b0;
            tc[i]    <= 1'b1;
          end
        end
      end

      if (we && addr == REG_CLRMASK) mask <= '0;
      if (we && addr == REG_ALLMASK) mask <= wdata[NCH-1:0];
    end
  end
endmodule

// File: rtl/dmac_arb.sv
`timescale 1ns/1ps
module dmac_arb #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0]                      req,
  output logic                                gnt_vld,
  output logic [((NCH>1)?$clog2(NCH):1)-1:0]  gnt_idx
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  always_comb begin
    gnt_vld = |req;
    gnt_idx = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (req[i]) gnt_idx = CHW'(i);
  end
endmodule

// File: rtl/dmac_seq.sv
`timescale 1ns/1ps
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                mclr,
  input  logic                                gnt_vld,
  input  logic [((NCH>1)?$clog2(NCH):1)-1:0]  gnt_idx,
  input  logic                                hlda,
  input  logic [NCH-1:0]                      drq,
  input  logic [NCH-1:0]                      demand,
  input  logic [NCH-1:0]                      dir,
  input  logic [AW-1:0]                       sel_addr,
  input  logic [CW-1:0]                       sel_cnt,
  output logic                                hrq,
  output logic [NCH-1:0]                      dack_n,
  output logic [AW-1:0]                       mem_addr,
  output logic                                memr_n,
  output logic                                memw_n,
  output logic                                ior_n,
  output logic                                iow_n,
  output logic                                eop_n,
  output logic                                step,
  output logic [((NCH>1)?$clog2(NCH):1)-1:0]  chan
);
  seq_state_t state;
  logic cur_dir, cur_demand, cur_drq;

  assign cur_dir    = dir[chan];
  assign cur_demand = demand[chan];
  assign cur_drq    = drq[chan];
  assign step       = (state == SQ_XFER);

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      state    <= SQ_IDLE;
      hrq      <= 1'b0;
      dack_n   <= '1;
      mem_addr <= '0;
      memr_n   <= 1'b1;
      memw_n   <= 1'b1;
      ior_n    <= 1'b1;
      iow_n    <= 1'b1;
      eop_n    <= 1'b1;
      chan     <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (gnt_vld && !hlda) begin
          chan  <= gnt_idx;
          hrq   <= 1'b1;
          state <= SQ_WAIT;
        end
        SQ_WAIT: if (hlda) begin
          state    <= SQ_XFER;
          dack_n   <= ~(NCH'(1) << chan);
          memr_n   <= cur_dir;
          iow_n    <= cur_dir;
          ior_n    <= !cur_dir;
          memw_n   <= !cur_dir;
          mem_addr <= sel_addr;
          eop_n    <= !(sel_cnt == CW'(1));
        end
        SQ_XFER: begin
          if (!eop_n || (cur_demand && !cur_drq)) begin
            state  <= SQ_IDLE;
            hrq    <= 1'b0;
            dack_n <= '1;
            memr_n <= 1'b1;
            memw_n <= 1'b1;
            ior_n  <= 1'b1;
            iow_n  <= 1'b1;
            eop_n  <= 1'b1;
          end else begin
            mem_addr <= sel_addr + 1'b1;
            eop_n    <= !(sel_cnt == CW'(2));
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmac_core.sv
`timescale 1ns/1ps
module dmac_core
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int DW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  drq,
  output logic [NCH-1:0]  dack_n,
  output logic            hrq,
  input  logic            hlda,
  output logic [AW-1:0]   mem_addr,
  output logic            memr_n,
  output logic            memw_n,
  output logic            ior_n,
  output logic            iow_n,
  output logic            eop_n,
  input  logic            cpu_we,
  input  logic            cpu_re,
  input  logic [RAW-1:0]  cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0][AW-1:0] cur_addr;
  logic [NCH-1:0][CW-1:0] cur_cnt;
  logic [NCH-1:0]         armed, mask, dir, demand, eligible;
  logic                   mclr, step, gnt_vld;
  logic [CHW-1:0]         chan, gnt_idx;

  assign eligible = drq & armed & ~mask;

  dmac_regs #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(cpu_we), .re(cpu_re), .addr(cpu_addr),
    .wdata(cpu_wdata), .drq(drq), .step(step), .step_ch(chan),
    .rdata(cpu_rdata), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
    .armed(armed), .mask(mask), .dir(dir), .demand(demand), .mclr(mclr)
  );

  dmac_arb #(.NCH(NCH)) u_arb (
    .req(eligible), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  dmac_seq #(.NCH(NCH), .AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .mclr(mclr), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx),
    .hlda(hlda), .drq(drq), .demand(demand), .dir(dir),
    .sel_addr(cur_addr[chan]), .sel_cnt(cur_cnt[chan]),
    .hrq(hrq), .dack_n(dack_n), .mem_addr(mem_addr), .memr_n(memr_n),
    .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .eop_n(eop_n),
    .step(step), .chan(chan)
  );
endmodule

// File: rtl/dmac_core_chk.sv
`timescale 1ns/1ps
module dmac_core_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           hrq,
  input logic           hlda,
  input logic [NCH-1:0] dack_n,
  input logic [AW-1:0]  mem_addr,
  input logic           memr_n,
  input logic           memw_n,
  input logic           ior_n,
  input logic           iow_n,
  input logic           eop_n
);
  p_one_dack_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dack_n));

  p_dack_needs_grant_r4: assert property (@(posedge clk) disable iff (rst)
    (dack_n != '1) |-> (hrq && hlda));

  p_strobe_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (dack_n != '1) |-> ((memr_n != ior_n) && (memr_n == iow_n) && (ior_n == memw_n)));

  p_quiet_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (dack_n == '1) |-> (memr_n && memw_n && ior_n && iow_n && eop_n));

  p_eop_in_byte_r7: assert property (@(posedge clk) disable iff (rst)
    !eop_n |-> (dack_n != '1));

  p_release_after_eop_r7: assert property (@(posedge clk) disable iff (rst)
    !eop_n |=> !hrq);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    ((dack_n != '1) && ($past(dack_n) == dack_n)) |-> (mem_addr == $past(mem_addr) + 1'b1));
endmodule

bind dmac_core dmac_core_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .hrq(hrq), .hlda(hlda), .dack_n(dack_n),
  .mem_addr(mem_addr), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
  .iow_n(iow_n), .eop_n(eop_n)
);

// File: tb/dmac_core_test.sv
`timescale 1ns/1ps
module dmac_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  drq = '0;
  logic        hlda = 1'b0;
  logic        cpu_we = 1'b0, cpu_re = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [3:0]  dack_n;
  logic        hrq, memr_n, memw_n, ior_n, iow_n, eop_n;
  logic [15:0] mem_addr;
  logic [7:0]  cpu_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  int          nb, neop, eop_at;
  logic [15:0] a0;
  bit          bad;
  logic [7:0]  rd;

  always #2.5 clk = ~clk;

  dmac_core uut (
    .clk(clk), .rst(rst), .drq(drq), .dack_n(dack_n), .hrq(hrq), .hlda(hlda),
    .mem_addr(mem_addr), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
    .iow_n(iow_n), .eop_n(eop_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [7:0] d);
    cpu_addr = a; cpu_re = 1'b1;
    @(negedge clk);
    d = cpu_rdata;
    cpu_re = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [15:0] sa, input logic [15:0] cnt,
                      input bit dev2mem, input bit dmd, input bit unmask);
    wr(4'd11, 8'h00);
    wr(4'(2*ch), sa[7:0]);   wr(4'(2*ch), sa[15:8]);
    wr(4'(2*ch+1), cnt[7:0]); wr(4'(2*ch+1), cnt[15:8]);
    wr(4'd10, {4'b0, dmd, dev2mem, 2'(ch)});
    if (unmask) wr(4'd9, {5'b0, 1'b0, 2'(ch)});
  endtask

  // Observe n cycles; count cycles with hrq high.
  task automatic quiet(input int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (hrq || dack_n != 4'hF) hits++;
    end
  endtask

  // Grant the bus once and record the burst.
  task automatic serve(input int ch, input bit dev2mem, input int stop_after);
    int w;
    logic [15:0] prev;
    nb = 0; neop = 0; eop_at = -1; bad = 0; a0 = '0; prev = '0; w = 0;
    while (!hrq && w < 40) begin @(negedge clk); w++; end
    if (!hrq) begin bad = 1; return; end
    hlda = 1'b1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (dack_n != 4'hF) begin
        if (dack_n != 4'(~(4'b1 << ch))) bad = 1;
        if (dev2mem ? (ior_n | memw_n | !memr_n | !iow_n)
                    : (memr_n | iow_n | !ior_n | !memw_n)) bad = 1;
        if (nb == 0) a0 = mem_addr;
        else if (mem_addr != prev + 16'd1) bad = 1;
        prev = mem_addr;
        if (!eop_n) begin neop++; eop_at = nb; end
        nb++;
        if (nb == stop_after) drq[ch] = 1'b0;
      end
      if (!hrq) break;
    end
    hlda = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    int h;
    chk("R1 hrq", hrq, 0);
    chk("R1 dack_n", dack_n, 4'hF);
    chk("R1 strobes+eop", {memr_n, memw_n, ior_n, iow_n, eop_n}, 5'h1F);
    prog(0, 16'h0040, 16'd2, 1'b1, 1'b0, 1'b0);
    drq[0] = 1'b1;
    quiet(10, h);
    chk("R1 masked after reset", h, 0);
    drq[0] = 1'b0;
  endtask

  task automatic t_unarmed;
    int h;
    wr(4'd9, 8'h03);               // unmask ch3, never armed
    drq[3] = 1'b1;
    quiet(10, h);
    chk("R2 unarmed channel ignored", h, 0);
    prog(3, 16'h0000, 16'd0, 1'b0, 1'b0, 1'b1);
    quiet(10, h);
    chk("R2 zero count not armed", h, 0);
    drq[3] = 1'b0;
  endtask

  task automatic t_block;
    int h;
    wr(4'd8, 8'h00);
    prog(2, 16'h1234, 16'd4, 1'b1, 1'b0, 1'b1);
    rdreg(4'd8, rd);               // drain status
    drq[2] = 1'b1;
    serve(2, 1'b1, 1);             // drop request after first byte
    chk("R8 block runs full count", nb, 4);
    chk("R5 first address", a0, 16'h1234);
    chk("R5 one dack, strobes, stepping", bad, 0);
    chk("R7 single eop", neop, 1);
    chk("R7 eop on last byte", eop_at, 3);
    rdreg(4'd8, rd);
    chk("R12 tc flag ch2", rd, 8'h04);
    rdreg(4'd8, rd);
    chk("R12 tc cleared by read", rd, 8'h00);
    drq[2] = 1'b1;
    quiet(10, h);
    chk("R7 channel dead after tc", h, 0);
    rdreg(4'd8, rd);
    chk("R12 request bits", rd, 8'h40);
    prog(2, 16'h2000, 16'd1, 1'b1, 1'b0, 1'b1);
    serve(2, 1'b1, 0);
    chk("R7 reprogram revives", {nb[7:0], a0}, {8'd1, 16'h2000});
    drq[2] = 1'b0;
  endtask

  task automatic t_priority;
    prog(1, 16'h0300, 16'd2, 1'b0, 1'b0, 1'b1);
    prog(3, 16'h0500, 16'd2, 1'b1, 1'b0, 1'b1);
    drq[1] = 1'b1; drq[3] = 1'b1;
    serve(1, 1'b0, 0);
    chk("R3 higher channel first", {bad, nb[7:0], a0}, {1'b0, 8'd2, 16'h0300});
    serve(3, 1'b1, 0);
    chk("R3 lower channel next", {bad, nb[7:0], a0}, {1'b0, 8'd2, 16'h0500});
    drq[1] = 1'b0; drq[3] = 1'b0;
  endtask

  task automatic t_wrap;
    prog(0, 16'hFFFE, 16'd3, 1'b1, 1'b0, 1'b1);
    drq[0] = 1'b1;
    serve(0, 1'b1, 0);
    chk("R6 wrap burst", {bad, nb[7:0], a0}, {1'b0, 8'd3, 16'hFFFE});
    drq[0] = 1'b0;
    wr(4'd11, 8'h00);
    rdreg(4'd0, rd); chk("R6 address low after wrap", rd, 8'h01);
    rdreg(4'd0, rd); chk("R6 address high after wrap", rd, 8'h00);
  endtask

  task automatic t_demand;
    int h;
    prog(1, 16'h0100, 16'd5, 1'b0, 1'b1, 1'b1);
    drq[1] = 1'b1;
    serve(1, 1'b0, 2);
    chk("R9 pause after request drop", {bad, nb[7:0], neop[7:0]}, {1'b0, 8'd2, 8'd0});
    quiet(8, h);
    chk("R9 bus released while paused", h, 0);
    wr(4'd11, 8'h00);
    rdreg(4'd2, rd); chk("R9 held address low", rd, 8'h02);
    rdreg(4'd2, rd); chk("R9 held address high", rd, 8'h01);
    rdreg(4'd3, rd); chk("R9 held count", rd, 8'h03);
    drq[1] = 1'b1;
    serve(1, 1'b0, 0);
    chk("R9 resume burst", {bad, nb[7:0], a0}, {1'b0, 8'd3, 16'h0102});
    chk("R9 eop at end of resumed burst", eop_at, 2);
    drq[1] = 1'b0;
  endtask

  task automatic t_pointer;
    wr(4'd11, 8'h00);
    wr(4'd0, 8'h11);
    wr(4'd11, 8'h00);
    wr(4'd0, 8'h22);
    wr(4'd0, 8'h33);
    wr(4'd11, 8'h00);
    rdreg(4'd0, rd); chk("R10 low byte after pointer clear", rd, 8'h22);
    rdreg(4'd0, rd); chk("R10 high byte", rd, 8'h33);
  endtask

  task automatic t_masks;
    int h;
    prog(2, 16'h0700, 16'd1, 1'b1, 1'b0, 1'b1);
    wr(4'd12, 8'h00);              // master clear: disarm and mask
    wr(4'd13, 8'h00);
    drq[2] = 1'b1;
    quiet(8, h);
    chk("R11 master clear disarms", h, 0);
    prog(2, 16'h0700, 16'd1, 1'b1, 1'b0, 1'b0);
    wr(4'd12, 8'h00);
    prog(2, 16'h0710, 16'd1, 1'b1, 1'b0, 1'b0);
    quiet(8, h);
    chk("R11 master clear masks", h, 0);
    wr(4'd13, 8'h00);
    serve(2, 1'b1, 0);
    chk("R11 clear-all-mask enables", {bad, nb[7:0], a0}, {1'b0, 8'd1, 16'h0710});
    wr(4'd14, 8'h0B);              // mask ch0,1,3
    prog(0, 16'h0900, 16'd1, 1'b1, 1'b0, 1'b0);
    prog(2, 16'h0A00, 16'd1, 1'b1, 1'b0, 1'b0);
    drq[0] = 1'b1; drq[2] = 1'b1;
    serve(2, 1'b1, 0);
    chk("R11 write-all-mask skips ch0", {bad, nb[7:0], a0}, {1'b0, 8'd1, 16'h0A00});
    wr(4'd9, 8'h04);               // set mask ch0 again (already set)
    quiet(6, h);
    chk("R11 single mask holds ch0", h, 0);
    wr(4'd9, 8'h00);
    serve(0, 1'b1, 0);
    chk("R11 single unmask ch0", {bad, nb[7:0], a0}, {1'b0, 8'd1, 16'h0900});
    drq = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_block();
    t_priority();
    t_wrap();
    t_demand();
    t_pointer();
    t_masks();
    chk("R4 bus idle at end", {hrq, dack_n}, 5'h0F);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule